// File: doc/BRIEF.md
# Multi-Width Integer Adder with Status Flags

This block is a purely combinational integer adder for an execution datapath. It adds a destination operand to a source operand at one of four widths (8, 16, 32 or 64 bits), picked per operation by a two-bit size code. With the result it produces six status flags: unsigned carry, signed overflow, sign, zero, nibble carry and low-byte parity.

The source operand is either a full register value or an immediate. An immediate arrives as a short 8-bit value or a long 32-bit value, and it is sign-extended to the selected width before the add. Operand bits above the selected width are ignored. Result bits above that width are driven to zero, so the datapath can write the result back without further masking.

Each width has its own adder lane, built from one parameterised lane module. A selector then picks the lane result and flags that match the size code.

Top module: `multiflag_adder`

## Requirements
- R1: `result_o` holds the low bits of `dst_i` plus the second operand, truncated to the width chosen by `size_sel` (0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits).
- R2: Every bit of `result_o` above the selected width is 0.
- R3: When `use_imm` is 1, the second operand is the immediate and `src_i` has no effect. The immediate is `imm_i[7:0]` when `imm_long` is 0 and `imm_i[31:0]` when `imm_long` is 1, sign-extended from its top bit (bit 7 or bit 31) to the selected width. When `use_imm` is 0, the second operand is `src_i`.
- R4: `cf_o` is 1 exactly when the unsigned sum at the selected width does not fit, which means a carry leaves the top bit of that width.
- R5: `of_o` is 1 exactly when both operands have the same top bit at the selected width and the result's top bit differs from it.
- R6: `sf_o` equals the top bit of the result at the selected width.
- R7: `zf_o` is 1 exactly when all result bits within the selected width are 0.
- R8: `af_o` is 1 exactly when adding bits 3..0 of the two operands carries into bit 4.
- R9: `pf_o` is 1 exactly when bits 7..0 of the result hold an even number of ones, at every width.
- R10: Operand bits above the selected width (in `dst_i`, `src_i` and the extended immediate) affect neither the result nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| size_sel | input | 2 | Operation width code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Register source operand |
| imm_i | input | 32 | Immediate source value |
| use_imm | input | 1 | 1 selects the immediate as the second operand |
| imm_long | input | 1 | 0 = 8-bit immediate, 1 = 32-bit immediate |
| result_o | output | 64 | Sum at the selected width, zero above it |
| cf_o | output | 1 | Unsigned carry out of the top bit |
| of_o | output | 1 | Signed overflow |
| sf_o | output | 1 | Sign of the result |
| zf_o | output | 1 | Result is zero |
| af_o | output | 1 | Carry from bit 3 into bit 4 |
| pf_o | output | 1 | Even number of ones in the low result byte |

## Verification
At byte width, every pair of operand values is tried, each with random bits above the byte. This covers every carry, overflow, nibble-carry and parity combination, and it also shows whether the high operand bits leak into the result. At the three wider widths, fixed patterns sit on the edges of the unsigned and signed ranges: all ones plus one, the most positive value plus one, the most negative value plus itself, and zero plus zero. These patterns separate the carry flag from the overflow flag and catch a flag taken from the wrong bit position. Immediate cases use values with the top bit set and clear, in both short and long form, together with a nonzero `src_i`. They show whether sign extension reaches the selected width and whether the register source is really ignored. Random vectors at all widths complete the sweep.

// File: rtl/addf_pkg.sv
package addf_pkg;
  localparam int unsigned DATA_W       = 64;
  localparam int unsigned NUM_WIDTHS   = 4;
  localparam int unsigned SEL_W        = $clog2(NUM_WIDTHS);
  localparam int unsigned IMM_W        = 32;
  localparam int unsigned IMM_SHORT_W  = 8;
  localparam int unsigned BASE_LANE_W  = 8;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } flags_t;

  // Width in bits of lane number idx: 8, 16, 32, 64.
  function automatic int unsigned lane_bits(input int unsigned idx);
    return BASE_LANE_W << idx;
  endfunction

  // Sign-extend the low from_w bits of v to DATA_W bits.
  function automatic logic [DATA_W-1:0] sign_extend(input logic [IMM_W-1:0] v,
                                                    input int unsigned from_w);
    logic [DATA_W-1:0] ext;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      ext[i] = (i < from_w) ? v[i] : v[from_w-1];
    end
    return ext;
  endfunction

  // Even parity indicator for one byte.
  function automatic logic even_ones(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/addf_operand_sel.sv
module addf_operand_sel #(
  parameter int unsigned DATA_W      = addf_pkg::DATA_W,
  parameter int unsigned IMM_W       = addf_pkg::IMM_W,
  parameter int unsigned IMM_SHORT_W = addf_pkg::IMM_SHORT_W
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm,
  input  logic              imm_long,
  output logic [DATA_W-1:0] operand_b
);
  logic [DATA_W-1:0] imm_short_ext;
  logic [DATA_W-1:0] imm_long_ext;

  always_comb begin
    imm_short_ext = addf_pkg::sign_extend(imm_i, IMM_SHORT_W);
    imm_long_ext  = addf_pkg::sign_extend(imm_i, IMM_W);
    if (!use_imm)      operand_b = src_i;
    else if (imm_long) operand_b = imm_long_ext;
    else               operand_b = imm_short_ext;
  end
endmodule

// File: rtl/addf_lane_adder.sv
module addf_lane_adder #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] sum_o,
  output logic              carry_out_o,
  output logic              carry_into_top_o,
  output logic              nibble_carry_o
);
  logic [LANE_W:0]   wide_sum;
  logic [LANE_W-1:0] carry_in_vec;

  always_comb begin
    wide_sum         = {1'b0, a_i} + {1'b0, b_i};
    sum_o            = wide_sum[LANE_W-1:0];
    carry_out_o      = wide_sum[LANE_W];
    // Carry entering each bit position is recovered from a ^ b ^ sum.
    carry_in_vec     = a_i ^ b_i ^ sum_o;
    carry_into_top_o = carry_in_vec[LANE_W-1];
    nibble_carry_o   = carry_in_vec[4];
  end
endmodule

// File: rtl/addf_flag_gen.sv
module addf_flag_gen #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0]     sum_i,
  input  logic                  carry_out_i,
  input  logic                  carry_into_top_i,
  input  logic                  nibble_carry_i,
  output addf_pkg::flags_t      flags_o
);
  always_comb begin
    flags_o.cf = carry_out_i;
    flags_o.of = carry_out_i ^ carry_into_top_i;
    flags_o.sf = sum_i[LANE_W-1];
    flags_o.zf = ~|sum_i;
    flags_o.af = nibble_carry_i;
    flags_o.pf = addf_pkg::even_ones(sum_i[7:0]);
  end
endmodule

// File: rtl/multiflag_adder.sv
module multiflag_adder #(
  parameter int unsigned DATA_W     = addf_pkg::DATA_W,
  parameter int unsigned IMM_W      = addf_pkg::IMM_W,
  parameter int unsigned NUM_WIDTHS = addf_pkg::NUM_WIDTHS
) (
  input  logic [$clog2(NUM_WIDTHS)-1:0] size_sel,
  input  logic [DATA_W-1:0]             dst_i,
  input  logic [DATA_W-1:0]             src_i,
  input  logic [IMM_W-1:0]              imm_i,
  input  logic                          use_imm,
  input  logic                          imm_long,
  output logic [DATA_W-1:0]             result_o,
  output logic                          cf_o,
  output logic                          of_o,
  output logic                          sf_o,
  output logic                          zf_o,
  output logic                          af_o,
  output logic                          pf_o
);
  localparam int unsigned SEL_W = $clog2(NUM_WIDTHS);

  logic [DATA_W-1:0]  op_b;
  logic [DATA_W-1:0]  lane_res   [NUM_WIDTHS];
  addf_pkg::flags_t   lane_flags [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] lane_carry_top;
  addf_pkg::flags_t   sel_flags;

  addf_operand_sel #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_opsel (
    .src_i     (src_i),
    .imm_i     (imm_i),
    .use_imm   (use_imm),
    .imm_long  (imm_long),
    .operand_b (op_b)
  );

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_lane
    localparam int unsigned LW = addf_pkg::lane_bits(g);
    logic [LW-1:0] l_sum;
    logic          l_cout;
    logic          l_ctop;
    logic          l_nib;

    addf_lane_adder #(.LANE_W(LW)) u_add (
      .a_i              (dst_i[LW-1:0]),
      .b_i              (op_b[LW-1:0]),
      .sum_o            (l_sum),
      .carry_out_o      (l_cout),
      .carry_into_top_o (l_ctop),
      .nibble_carry_o   (l_nib)
    );

    addf_flag_gen #(.LANE_W(LW)) u_flags (
      .sum_i            (l_sum),
      .carry_out_i      (l_cout),
      .carry_into_top_i (l_ctop),
      .nibble_carry_i   (l_nib),
      .flags_o          (lane_flags[g])
    );

    assign lane_res[g]       = DATA_W'(l_sum);
    assign lane_carry_top[g] = l_ctop;
  end

  logic [SEL_W-1:0] sel_idx;
  assign sel_idx = size_sel;

  always_comb begin
    result_o  = lane_res[sel_idx];
    sel_flags = lane_flags[sel_idx];
    cf_o = sel_flags.cf;
    of_o = sel_flags.of;
    sf_o = sel_flags.sf;
    zf_o = sel_flags.zf;
    af_o = sel_flags.af;
    pf_o = sel_flags.pf;
  end
endmodule

// File: rtl/addf_checker.sv
module addf_checker (
  input logic [1:0]  size_sel,
  input logic [63:0] dst_i,
  input logic [63:0] op_b,
  input logic [63:0] result_o,
  input logic        cf_o,
  input logic        of_o,
  input logic        sf_o,
  input logic        zf_o,
  input logic        af_o,
  input logic        pf_o
);
  logic [63:0] wmask;
  int unsigned msb;
  logic        a_top, b_top, r_top;

  always_comb begin
    case (size_sel)
      2'd0:    begin wmask = 64'h0000_0000_0000_00FF; msb = 7;  end
      2'd1:    begin wmask = 64'h0000_0000_0000_FFFF; msb = 15; end
      2'd2:    begin wmask = 64'h0000_0000_FFFF_FFFF; msb = 31; end
      default: begin wmask = 64'hFFFF_FFFF_FFFF_FFFF; msb = 63; end
    endcase
    a_top = dst_i[msb];
    b_top = op_b[msb];
    r_top = result_o[msb];

    AST_SUM_MATCH: assert (result_o == ((dst_i + op_b) & wmask)); // R1
    AST_UPPER_CLEAR: assert ((result_o & ~wmask) == 64'd0); // R2
    AST_CARRY_WRAP: assert (cf_o == (result_o < (dst_i & wmask))); // R4
    AST_NO_OVERFLOW: assert (of_o == ((a_top == b_top) && (r_top != a_top))); // R5
    AST_SIGN_FLAG: assert (sf_o == r_top); // R6
    AST_ZERO_FLAG: assert (zf_o == (result_o == 64'd0)); // R7
    AST_NIBBLE_CARRY: assert (af_o == ((5'(dst_i[3:0]) + 5'(op_b[3:0])) > 5'd15)); // R8
    AST_LOW_PARITY: assert (pf_o == ($countones(result_o[7:0]) % 2 == 0)); // R9
  end
endmodule

bind multiflag_adder addf_checker u_chk (
  .size_sel (size_sel),
  .dst_i    (dst_i),
  .op_b     (op_b),
  .result_o (result_o),
  .cf_o     (cf_o),
  .of_o     (of_o),
  .sf_o     (sf_o),
  .zf_o     (zf_o),
  .af_o     (af_o),
  .pf_o     (pf_o)
);

// File: tb/multiflag_adder_tb.sv
module multiflag_adder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = '0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [31:0] imm_i = '0;
  logic        use_imm = 1'b0, imm_long = 1'b0;
  logic [63:0] result_o;
  logic        cf_o, of_o, sf_o, zf_o, af_o, pf_o;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  multiflag_adder u_dut (
    .size_sel (size_sel), .dst_i (dst_i), .src_i (src_i), .imm_i (imm_i),
    .use_imm (use_imm), .imm_long (imm_long), .result_o (result_o),
    .cf_o (cf_o), .of_o (of_o), .sf_o (sf_o), .zf_o (zf_o), .af_o (af_o), .pf_o (pf_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s sel=%0d dst=%h src=%h imm=%h ui=%0b il=%0b actual=%h expected=%h",
               req, size_sel, dst_i, src_i, imm_i, use_imm, imm_long, act, exp);
    end
  endtask

  // Independent reference: arithmetic written from the requirements.
  task automatic run(input logic [1:0] sel, input logic [63:0] d, input logic [63:0] s,
                     input logic [31:0] im, input logic ui, input logic il);
    int unsigned w;
    logic [63:0] mask, b, am, bm, res;
    logic [64:0] full;
    logic cf, of, sf, zf, af, pf;
    int ones;
    @(negedge clk);
    size_sel = sel; dst_i = d; src_i = s; imm_i = im; use_imm = ui; imm_long = il;
    #2;
    w    = 8 << sel;
    mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    if (!ui)      b = s;
    else if (il)  b = im[31] ? ({32'd0, im} | 64'hFFFF_FFFF_0000_0000) : {32'd0, im};
    else          b = im[7]  ? ({56'd0, im[7:0]} | ~64'hFF) : {56'd0, im[7:0]};
    am   = d & mask;
    bm   = b & mask;
    full = {1'b0, am} + {1'b0, bm};
    res  = full[63:0] & mask;
    cf   = full[w];
    of   = (am[w-1] == bm[w-1]) && (res[w-1] != am[w-1]);
    sf   = res[w-1];
    zf   = (res == 64'd0);
    af   = ((am & 64'hF) + (bm & 64'hF)) > 64'd15;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(res[i]);
    pf   = (ones % 2) == 0;
    chk("R1", result_o & mask, res);
    chk("R2", result_o & ~mask, 64'd0);
    chk("R4", {63'd0, cf_o}, {63'd0, cf});
    chk("R5", {63'd0, of_o}, {63'd0, of});
    chk("R6", {63'd0, sf_o}, {63'd0, sf});
    chk("R7", {63'd0, zf_o}, {63'd0, zf});
    chk("R8", {63'd0, af_o}, {63'd0, af});
    chk("R9", {63'd0, pf_o}, {63'd0, pf});
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: all-zero inputs give zero result with zero and parity set (R7, R9).
    run(2'd3, 64'd0, 64'd0, 32'd0, 1'b0, 1'b0);

    // R10: byte width exhaustive, with random garbage above the byte.
    for (int a = 0; a < 256; a++) begin
      for (int c = 0; c < 256; c++) begin
        logic [63:0] hd, hs;
        hd = rnd64(); hs = rnd64();
        run(2'd0, {hd[63:8], a[7:0]}, {hs[63:8], c[7:0]}, 32'd0, 1'b0, 1'b0);
      end
    end

    // R4 R5 boundary patterns at every width.
    for (int sl = 0; sl < 4; sl++) begin
      logic [63:0] mx, smx, smn;
      int unsigned w;
      w   = 8 << sl;
      mx  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      smx = mx >> 1;
      smn = smx + 64'd1;
      run(sl[1:0], mx,  64'd1, 32'd0, 1'b0, 1'b0);
      run(sl[1:0], mx,  mx,    32'd0, 1'b0, 1'b0);
      run(sl[1:0], smx, 64'd1, 32'd0, 1'b0, 1'b0);
      run(sl[1:0], smn, smn,   32'd0, 1'b0, 1'b0);
      run(sl[1:0], smx, smn,   32'd0, 1'b0, 1'b0);
      run(sl[1:0], smn, mx,    32'd0, 1'b0, 1'b0);
      run(sl[1:0], 64'h0F, 64'h01, 32'd0, 1'b0, 1'b0);
      run(sl[1:0], ~mx | 64'd5, ~mx | 64'd3, 32'd0, 1'b0, 1'b0);
      // R3: immediates, both forms and signs, with a nonzero src_i that must be ignored.
      run(sl[1:0], 64'd1,  64'hDEAD_BEEF_0123_4567, 32'h0000_0080, 1'b1, 1'b0);
      run(sl[1:0], 64'd1,  64'hDEAD_BEEF_0123_4567, 32'h0000_007F, 1'b1, 1'b0);
      run(sl[1:0], 64'd1,  64'hDEAD_BEEF_0123_4567, 32'hFFFF_FFFF, 1'b1, 1'b0);
      run(sl[1:0], 64'd0,  64'h1111_1111_1111_1111, 32'h8000_0000, 1'b1, 1'b1);
      run(sl[1:0], 64'd5,  64'h1111_1111_1111_1111, 32'h7FFF_FFFF, 1'b1, 1'b1);
      run(sl[1:0], 64'd1,  64'h1111_1111_1111_1111, 32'hFFFF_FF00, 1'b1, 1'b1);
    end

    // R1 R3 R10: random vectors at all widths and operand sources.
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      run(rv[1:0], rnd64(), rnd64(), $urandom, rv[2], rv[3]);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule